// File: doc/BRIEF.md
# Halt Wakeup Timer

This block wakes a halted processor after a programmable interval. While the enable bit of its 8-bit control register is set, it counts ticks of a slow time base. These ticks arrive as a one-cycle enable from an external prescaler, about 32 microseconds apart. When the selected number of ticks has passed, the block raises either an interrupt request or a reset request for one clock cycle. It then starts counting the next interval.

Software programs the block by writing the control register and can read it back at any time. The period field is a 6-bit one-hot code. If several bits are set, the lowest set bit decides the period. Every write restarts the interval from zero, so software can postpone the wakeup by writing the register again.

Top module: `halt_wakeup_timer`

## Requirements
- R1: After reset the register reads 00h and neither request output is high.
- R2: The register reads back exactly the last written byte, including a period field with several bits set. Bit 7 is the enable, bit 6 is the action select and bits 5:0 are the period field.
- R3: The interval in ticks is 2^(6+2k), where k is the position of the lowest set bit of the period field. An all-zero field gives 2^6. So 000000 and 000001 give 64, 000010 gives 256, 000100 gives 1024, 001000 gives 4096, 010000 gives 16384 and 100000 gives 65536.
- R4: Only clock cycles with the tick input high advance the count, and only while the enable bit is 1. The request pulse is high in the cycle after the clock edge that samples the interval's last tick.
- R5: Each request pulse lasts exactly one cycle. The count then wraps to zero and keeps running, so pulses repeat every interval for as long as the timer stays enabled.
- R6: With bit 6 at 0 the pulse appears on `wake_irq`, and with bit 6 at 1 it appears on `wake_rst`. The two outputs are never high together.
- R7: A register write restarts the count from zero. A tick in the same cycle as a write is discarded, and no pulse results from that cycle.
- R8: While the enable bit is 0, no request pulse is produced and the count stays at zero. After the timer is enabled, the first pulse therefore comes a full interval later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| tick | input | 1 | One-cycle time-base enable from the prescaler |
| cfg_rdata | output | 8 | Control register readback |
| wake_irq | output | 1 | One-cycle interrupt request |
| wake_rst | output | 1 | One-cycle reset request |

## Verification
Directed runs are tried first.
- Single-bit period fields measure each interval length.
- Multi-bit fields such as 000110 and 111111 tell a lowest-bit priority decoder apart from a highest-bit one or a plain binary one.
- The 65536-tick setting exposes a counter that is too narrow.
- A write in the middle of a count, a write on the exact expiry cycle and a disabled period with ticks running tell restart and masking apart from free counting.
- A randomized run follows, with sparse ticks, occasional rewrites and mixed actions. It compares every cycle against a bench model, so an off-by-one in the expiry cycle or a pulse on the wrong output is caught.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
  localparam int unsigned PERIOD_BITS = 6;
  localparam int unsigned BASE_EXP    = 6;
  localparam int unsigned STEP_EXP    = 2;
  localparam int unsigned COUNT_BITS  = BASE_EXP + STEP_EXP * (PERIOD_BITS - 1);
  localparam int unsigned REG_BITS    = PERIOD_BITS + 2;

  typedef struct packed {
    logic                   enable;
    logic                   action_rst;
    logic [PERIOD_BITS-1:0] period;
  } hwt_cfg_t;

  // Keep only the lowest set bit of a period field.
  function automatic logic [PERIOD_BITS-1:0] lowest_one(input logic [PERIOD_BITS-1:0] f);
    return f & (~f + 1'b1);
  endfunction

  // Terminal count value (interval length minus one) for a given exponent.
  function automatic logic [COUNT_BITS-1:0] last_for_exp(input int unsigned e);
    logic [COUNT_BITS-1:0] ones;
    ones = '1;
    return ones >> (COUNT_BITS - e);
  endfunction
endpackage

// File: rtl/hwt_ctrl_reg.sv
module hwt_ctrl_reg
  import hwt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_BITS-1:0] wr_data,
  output hwt_cfg_t            cfg_q,
  output logic                restart
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= hwt_cfg_t'(wr_data);
  end

  assign restart = wr_en;
endmodule

// File: rtl/hwt_period_dec.sv
module hwt_period_dec
  import hwt_pkg::*;
#(
  parameter int unsigned P_BITS = PERIOD_BITS,
  parameter int unsigned C_BITS = COUNT_BITS,
  parameter int unsigned B_EXP  = BASE_EXP,
  parameter int unsigned S_EXP  = STEP_EXP
) (
  input  logic [P_BITS-1:0] period,
  output logic [C_BITS-1:0] last_cnt
);
  localparam logic [C_BITS-1:0] ALL_ONES = '1;

  logic [P_BITS-1:0] sel;
  logic [C_BITS-1:0] term [P_BITS];

  assign sel = period & (~period + 1'b1);

  for (genvar k = 0; k < P_BITS; k++) begin : g_term
    localparam int unsigned EXP_K = B_EXP + S_EXP * k;
    assign term[k] = sel[k] ? (ALL_ONES >> (C_BITS - EXP_K)) : '0;
  end

  always_comb begin
    last_cnt = '0;
    for (int k = 0; k < P_BITS; k++) last_cnt = last_cnt | term[k];
    if (period == '0) last_cnt = ALL_ONES >> (C_BITS - B_EXP);
  end
endmodule

// File: rtl/hwt_counter.sv
module hwt_counter #(
  parameter int unsigned C_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              tick,
  input  logic [C_BITS-1:0] last_cnt,
  output logic [C_BITS-1:0] cnt_q,
  output logic              tick_qual,
  output logic              expire
);
  assign tick_qual = enable & tick & ~restart;
  assign expire    = tick_qual & (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !enable) cnt_q <= '0;
    else if (expire)             cnt_q <= '0;
    else if (tick_qual)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hwt_pulse_out.sv
module hwt_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic action_rst,
  output logic irq_q,
  output logic rst_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= expire & ~action_rst;
      rst_q <= expire &  action_rst;
    end
  end
endmodule

// File: rtl/halt_wakeup_timer.sv
module halt_wakeup_timer
  import hwt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [REG_BITS-1:0] cfg_wdata,
  input  logic                tick,
  output logic [REG_BITS-1:0] cfg_rdata,
  output logic                wake_irq,
  output logic                wake_rst
);
  hwt_cfg_t              cfg_q;
  logic                  restart;
  logic [COUNT_BITS-1:0] last_cnt;
  logic [COUNT_BITS-1:0] cnt_q;
  logic                  tick_qual;
  logic                  expire;

  hwt_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .cfg_q(cfg_q), .restart(restart)
  );

  hwt_period_dec #(
    .P_BITS(PERIOD_BITS), .C_BITS(COUNT_BITS), .B_EXP(BASE_EXP), .S_EXP(STEP_EXP)
  ) u_dec (
    .period(cfg_q.period), .last_cnt(last_cnt)
  );

  hwt_counter #(.C_BITS(COUNT_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .enable(cfg_q.enable),
    .tick(tick), .last_cnt(last_cnt), .cnt_q(cnt_q),
    .tick_qual(tick_qual), .expire(expire)
  );

  hwt_pulse_out u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .action_rst(cfg_q.action_rst),
    .irq_q(wake_irq), .rst_q(wake_rst)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/hwt_checker.sv
module hwt_checker #(
  parameter int unsigned C_BITS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_rdata,
  input logic              wake_irq,
  input logic              wake_rst,
  input logic              tick_qual,
  input logic [C_BITS-1:0] cnt_q,
  input logic [C_BITS-1:0] last_cnt
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_qual && cnt_q != last_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> !wake_rst);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_irq && wake_rst));

  assert_irq_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> !cfg_rdata[6]);

  assert_rst_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |-> cfg_rdata[6]);

  assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt_q == '0 && !wake_irq && !wake_rst));

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> (cnt_q == '0 && !wake_irq && !wake_rst));
endmodule

bind halt_wakeup_timer hwt_checker #(.C_BITS(hwt_pkg::COUNT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .wake_irq(wake_irq), .wake_rst(wake_rst), .tick_qual(tick_qual),
  .cnt_q(cnt_q), .last_cnt(last_cnt)
);

// File: tb/test_halt_wakeup_timer.sv
module test_halt_wakeup_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       tick = 1'b0;
  logic [7:0] cfg_rdata;
  logic       wake_irq, wake_rst;

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit done = 1'b0;

  // bench reference state
  logic [7:0]  m_reg = 8'h00;
  int unsigned m_cnt = 0;
  logic        m_irq = 1'b0, m_rst = 1'b0;

  always #2 clk = ~clk;

  halt_wakeup_timer i_halt_wakeup_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick(tick), .cfg_rdata(cfg_rdata), .wake_irq(wake_irq), .wake_rst(wake_rst)
  );

  // Interval in ticks from the requirement table: 64 * 4^k, k = lowest set bit.
  function automatic int unsigned interval(input logic [7:0] r);
    for (int k = 0; k < 6; k++)
      if (r[k]) return 64 << (2 * k);
    return 64;
  endfunction

  task automatic check(input string rq);
    n_chk++;
    if (cfg_rdata !== m_reg || wake_irq !== m_irq || wake_rst !== m_rst) begin
      n_fail++;
      $display("FAIL %s: rdata/irq/rst actual %h/%b/%b expected %h/%b/%b (cycle %0d)",
               rq, cfg_rdata, wake_irq, wake_rst, m_reg, m_irq, m_rst, n_cyc);
    end
  endtask

  // One clock: check outputs, drive inputs, advance the model across the edge.
  task automatic step(input bit w, input logic [7:0] d, input bit t, input string rq);
    @(negedge clk);
    n_cyc++;
    check(rq);
    cfg_we = w; cfg_wdata = d; tick = t;
    m_irq = 1'b0; m_rst = 1'b0;
    if (w) begin
      m_reg = d; m_cnt = 0;
    end else if (!m_reg[7]) begin
      m_cnt = 0;
    end else if (t) begin
      if (m_cnt + 1 == interval(m_reg)) begin
        m_cnt = 0;
        if (m_reg[6]) m_rst = 1'b1; else m_irq = 1'b1;
      end else m_cnt++;
    end
  endtask

  task automatic run(input int n, input bit t, input string rq);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, t, rq);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1");                           // during reset
    rst_n = 1'b1;
    step(0, 8'h00, 1, "R1");
    run(100, 1, "R8");                     // disabled after reset, ticks ignored

    step(1, 8'h80, 0, "R2");               // 64 ticks, interrupt
    run(200, 1, "R4");
    step(1, 8'h81, 0, "R3");
    run(140, 1, "R5");
    step(1, 8'hC0, 0, "R6");               // reset action
    run(140, 1, "R6");
    step(1, 8'h82, 0, "R3");               // 256
    run(600, 1, "R3");
    step(1, 8'h86, 0, "R3");               // bits 1,2 set -> 256
    run(300, 1, "R3");
    step(1, 8'hBF, 0, "R2");               // all bits -> 64
    run(150, 1, "R3");
    step(1, 8'hC4, 0, "R3");               // 1024
    run(1100, 1, "R3");
    step(1, 8'h88, 0, "R3");               // 4096
    run(4200, 1, "R3");
    step(1, 8'hD0, 0, "R3");               // 16384
    run(16500, 1, "R3");
    step(1, 8'hA0, 0, "R3");               // 65536
    run(65600, 1, "R3");

    step(1, 8'h80, 0, "R7");               // mid-count rewrite
    run(30, 1, "R7");
    step(1, 8'hC0, 0, "R7");
    run(70, 1, "R7");
    step(1, 8'h80, 0, "R7");               // write on the expiry tick
    run(63, 1, "R7");
    step(1, 8'h80, 1, "R7");
    run(70, 1, "R7");

    step(1, 8'h3F, 0, "R8");               // disabled, period bits set
    run(300, 1, "R8");
    step(1, 8'h41, 0, "R8");
    run(200, 1, "R8");
    step(1, 8'h81, 0, "R8");               // full interval after enable
    run(70, 1, "R8");

    run(50, 0, "R4");                      // no ticks: no advance
    for (int i = 0; i < 200; i++) step(0, 8'h00, (i % 3) == 0, "R4");

    for (int i = 0; i < 8000; i++) begin   // randomized mix
      bit w, t;
      logic [7:0] d;
      w = ($urandom % 400) == 0;
      t = ($urandom % 10) < 6;
      d[5:0] = 6'($urandom) | 6'(1 << ($urandom % 3));
      d[6]   = 1'($urandom);
      d[7]   = ($urandom % 10) != 0;
      step(w, d, t, "R5");
    end
    run(2, 0, "R5");
    finish_up();
  end
endmodule